// File: doc/BRIEF.md
# JTAG System Memory Access Port

This block lets an external debugger reach any physical memory location through JTAG, with no processor involved. It holds a full TAP controller, an 8-bit instruction register and three data registers selected by instruction value. The first data register holds the upper address bits. The second is a 64-bit command register that packs the access size, the direction and a 32-bit address. The third is a data register whose scan length is eight bits per byte of the access.

A read is a command scan with the read bit set, followed by a data scan that returns the bytes on TDO. A write is a command scan with the read bit clear, followed by a data scan whose Update-DR sends the bytes to memory. Each transfer is a single beat. The request is carried from the TCK domain into the system clock domain with a toggle handshake, and it leaves the block on a valid/ready request channel.

Back-pressure rules: `mem_req_valid` stays high, with all request fields held stable, until the cycle in which `mem_req_ready` is sampled high. Only one request is in flight at a time. A read is not complete until `mem_rsp_valid` has been seen, and no new request appears before then. The response channel has no back-pressure: the block accepts `mem_rsp_valid` in any cycle while it waits for a read.

Top module: `sap_mem_port`

## Requirements
- R1: The TAP enters Test-Logic-Reset when trst_n is low, or after five consecutive TCK rising edges with TMS high. Entering that state loads the instruction register with 0xFF, which selects bypass. mem_req_valid is low while rst_n is asserted.
- R2: The instruction register is 8 bits wide and is shifted LSB first. Capture-IR loads 0x01, so the first IR scan after reset returns 0x01.
- R3: Instruction 0x21 selects a 16-bit upper-address register. It is written at Update-DR, and Capture-DR loads its held value. It forms bits 47:32 of mem_req_addr.
- R4: Instruction 0x24 selects a 64-bit command register with this layout: bits 11:9 hold the size in bytes, bit 12 is 1 for a read, bits 47:16 hold the address, and all other bits are reserved and zero. A valid read command issues exactly one read request at Update-DR, with address {upper, command address}.
- R5: After a read, a data scan under instruction 0x25 of 8*size bits returns the addressed bytes LSB first. These are the memory word shifted right by 8*address[1:0].
- R6: A 0x25 data scan that follows a write command issues exactly one write at its Update-DR. The write data is placed at byte lane address[1:0]. Byte enables follow the size: for size 1, 1 shifted left by address[1:0]; for size 2, 1100 when address[1] is set and 0011 otherwise; for size 4, 1111.
- R7: A command whose size is not 1, 2 or 4, or whose reserved bits are not all zero, issues no request. Neither does any data scan that follows it.
- R8: mem_req_valid holds, with stable fields, until mem_req_ready is sampled. No request is presented while a read waits for mem_rsp_valid.
- R9: Any instruction other than 0x21, 0x24 and 0x25 selects a 1-bit bypass register that captures 0. TDO then repeats TDI one bit later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | JTAG asynchronous reset, active low |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out, changes on falling TCK |
| clk | input | 1 | System clock for the memory side |
| rst_n | input | 1 | System reset, active low, asynchronous |
| mem_req_valid | output | 1 | Request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_HI_W+32 | Full byte address |
| mem_req_wdata | output | 32 | Write data, lane aligned |
| mem_req_be | output | 4 | Byte enables |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | 32 | Read word, lane aligned |

## Verification
The bench builds the block with ADDR_HI_W = 16 and two synchroniser stages. A nonzero upper address therefore reaches the top 16 bits of the 48-bit request, and the TCK-to-system crossing runs at its shortest latency against a 10:1 clock ratio. The memory model withholds ready in one cycle out of three, which exercises request hold under back-pressure. Reads of every size land on every byte lane, so each shift length and each lane extraction is covered.

// File: rtl/sap_pkg.sv
package sap_pkg;

  localparam int IR_W = 8;
  localparam int DW   = 32;
  localparam int BEW  = DW / 8;
  localparam int CMDW = 64;

  localparam logic [IR_W-1:0] IR_ADDR_HI = 8'h21;
  localparam logic [IR_W-1:0] IR_CMD     = 8'h24;
  localparam logic [IR_W-1:0] IR_DATA    = 8'h25;
  localparam logic [IR_W-1:0] IR_BYPASS  = 8'hFF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {B_IDLE, B_REQ, B_WAIT} bridge_state_e;

  function automatic logic size_ok(input logic [2:0] sz);
    return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
  endfunction

  function automatic logic [BEW-1:0] size_be(input logic [2:0] sz, input logic [1:0] a);
    logic [BEW-1:0] be;
    case (sz)
      3'd1:    be = 4'b0001 << a;
      3'd2:    be = a[1] ? 4'b1100 : 4'b0011;
      3'd4:    be = 4'b1111;
      default: be = '0;
    endcase
    return be;
  endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sap_tap_fsm.sv
module sap_tap_fsm
  import sap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      default:   nxt = TS_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= TS_RESET;
    else         state <= nxt;
  end
endmodule

// File: rtl/sap_dr_bank.sv
module sap_dr_bank
  import sap_pkg::*;
#(
  parameter int ADDR_HI_W = 16,
  localparam int AW = ADDR_HI_W + 32
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tdi,
  input  tap_state_e     state,
  input  logic           ack_s,
  input  logic [DW-1:0]  rdata,
  output logic           tdo,
  output logic           req_tgl,
  output logic [AW-1:0]  req_addr,
  output logic           req_wr,
  output logic [2:0]     req_size,
  output logic [DW-1:0]  req_wdata
);
  logic [IR_W-1:0]      ir_q, ir_sr;
  logic [ADDR_HI_W-1:0] hi_sr, hi_q;
  logic [CMDW-1:0]      cmd_sr;
  logic [DW-1:0]        dat_sr;
  logic                 byp_sr;
  logic [2:0]           cmd_size;
  logic                 cmd_rd, cmd_ok;
  logic [31:0]          cmd_addr;
  logic                 pending, new_ok, dr_out;
  logic [5:0]           nbits;
  logic [DW-1:0]        wr_aligned;

  assign pending = req_tgl ^ ack_s;

  always_comb begin
    new_ok = size_ok(cmd_sr[11:9]) && (cmd_sr[8:0] == '0) &&
             (cmd_sr[15:13] == '0) && (cmd_sr[63:48] == '0);
    nbits      = size_ok(cmd_size) ? {cmd_size, 3'b000} : 6'd32;
    wr_aligned = (dat_sr >> (6'd32 - nbits)) << {cmd_addr[1:0], 3'b000};
    case (ir_q)
      IR_ADDR_HI: dr_out = hi_sr[0];
      IR_CMD:     dr_out = cmd_sr[0];
      IR_DATA:    dr_out = dat_sr[0];
      default:    dr_out = byp_sr;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= IR_BYPASS;  ir_sr <= '0;
      hi_sr <= '0;  hi_q <= '0;  cmd_sr <= '0;  dat_sr <= '0;  byp_sr <= 1'b0;
      cmd_size <= '0;  cmd_rd <= 1'b0;  cmd_addr <= '0;  cmd_ok <= 1'b0;
      req_tgl <= 1'b0;  req_addr <= '0;  req_wr <= 1'b0;
      req_size <= '0;  req_wdata <= '0;
    end else begin
      case (state)
        TS_RESET:  ir_q  <= IR_BYPASS;
        TS_CAP_IR: ir_sr <= IR_CAPTURE;
        TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        TS_UPD_IR: ir_q  <= ir_sr;
        TS_CAP_DR: begin
          case (ir_q)
            IR_ADDR_HI: hi_sr  <= hi_q;
            IR_CMD:     cmd_sr <= {16'h0, cmd_addr, 3'b000, cmd_rd, cmd_size, 9'h000};
            IR_DATA:    dat_sr <= rdata;
            default:    byp_sr <= 1'b0;
          endcase
        end
        TS_SH_DR: begin
          case (ir_q)
            IR_ADDR_HI: hi_sr  <= {tdi, hi_sr[ADDR_HI_W-1:1]};
            IR_CMD:     cmd_sr <= {tdi, cmd_sr[CMDW-1:1]};
            IR_DATA:    dat_sr <= {tdi, dat_sr[DW-1:1]};
            default:    byp_sr <= tdi;
          endcase
        end
        TS_UPD_DR: begin
          case (ir_q)
            IR_ADDR_HI: hi_q <= hi_sr;
            IR_CMD: begin
              cmd_addr <= cmd_sr[47:16];
              cmd_rd   <= cmd_sr[12];
              cmd_size <= cmd_sr[11:9];
              cmd_ok   <= new_ok;
              if (new_ok && cmd_sr[12] && !pending) begin
                req_addr <= {hi_q, cmd_sr[47:16]};
                req_wr   <= 1'b0;
                req_size <= cmd_sr[11:9];
                req_tgl  <= ~req_tgl;
              end
            end
            IR_DATA: begin
              if (cmd_ok && !cmd_rd && !pending) begin
                req_addr  <= {hi_q, cmd_addr};
                req_wr    <= 1'b1;
                req_size  <= cmd_size;
                req_wdata <= wr_aligned;
                req_tgl   <= ~req_tgl;
              end
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                tdo <= 1'b0;
    else if (state == TS_SH_IR) tdo <= ir_sr[0];
    else if (state == TS_SH_DR) tdo <= dr_out;
  end
endmodule

// File: rtl/sap_mem_bridge.sv
module sap_mem_bridge
  import sap_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_tgl_s,
  input  logic [AW-1:0]  t_addr,
  input  logic           t_wr,
  input  logic [2:0]     t_size,
  input  logic [DW-1:0]  t_wdata,
  output logic           ack_tgl,
  output logic [DW-1:0]  rdata_q,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  output logic [BEW-1:0] mem_req_be,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_rdata
);
  bridge_state_e st;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= B_IDLE;  seen <= 1'b0;  ack_tgl <= 1'b0;  rdata_q <= '0;
      mem_req_valid <= 1'b0;  mem_req_write <= 1'b0;  mem_req_addr <= '0;
      mem_req_wdata <= '0;  mem_req_be <= '0;
    end else begin
      case (st)
        B_IDLE: if (req_tgl_s != seen) begin
          seen          <= req_tgl_s;
          mem_req_valid <= 1'b1;
          mem_req_write <= t_wr;
          mem_req_addr  <= t_addr;
          mem_req_wdata <= t_wdata;
          mem_req_be    <= size_be(t_size, t_addr[1:0]);
          st            <= B_REQ;
        end
        B_REQ: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          if (mem_req_write) begin
            ack_tgl <= ~ack_tgl;
            st      <= B_IDLE;
          end else begin
            st <= B_WAIT;
          end
        end
        B_WAIT: if (mem_rsp_valid) begin
          rdata_q <= mem_rsp_rdata >> {mem_req_addr[1:0], 3'b000};
          ack_tgl <= ~ack_tgl;
          st      <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sap_mem_port.sv
module sap_mem_port
  import sap_pkg::*;
#(
  parameter int ADDR_HI_W   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = ADDR_HI_W + 32
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tms,
  input  logic           tdi,
  output logic           tdo,
  input  logic           clk,
  input  logic           rst_n,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic           mem_req_write,
  output logic [AW-1:0]  mem_req_addr,
  output logic [DW-1:0]  mem_req_wdata,
  output logic [BEW-1:0] mem_req_be,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_rdata
);
  tap_state_e    tap_state;
  logic          req_tgl, req_tgl_s, ack_tgl, ack_s;
  logic [AW-1:0] t_addr;
  logic          t_wr;
  logic [2:0]    t_size;
  logic [DW-1:0] t_wdata, rdata_q;

  sap_tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(tap_state));

  sap_dr_bank #(.ADDR_HI_W(ADDR_HI_W)) u_bank (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(tap_state),
    .ack_s(ack_s), .rdata(rdata_q), .tdo(tdo),
    .req_tgl(req_tgl), .req_addr(t_addr), .req_wr(t_wr),
    .req_size(t_size), .req_wdata(t_wdata)
  );

  sap_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_tgl_s));

  sap_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(tck), .rst_n(trst_n), .d(ack_tgl), .q(ack_s));

  sap_mem_bridge #(.AW(AW)) u_bridge (
    .clk(clk), .rst_n(rst_n), .req_tgl_s(req_tgl_s),
    .t_addr(t_addr), .t_wr(t_wr), .t_size(t_size), .t_wdata(t_wdata),
    .ack_tgl(ack_tgl), .rdata_q(rdata_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );
endmodule

// File: rtl/sap_mem_port_chk.sv
module sap_mem_port_chk
  import sap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        tck,
  input logic        trst_n,
  input logic        tms,
  input tap_state_e  tap_state,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [3:0]  mem_req_be,
  input logic [31:0] mem_req_wdata,
  input logic        mem_rsp_valid
);
  logic [2:0] ones;
  logic       rd_pend;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      ones <= '0;
    else if (!tms)    ones <= '0;
    else if (ones < 3'd5) ones <= ones + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend <= 1'b1;
    else if (mem_rsp_valid) rd_pend <= 1'b0;
  end

  a_r1_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (tap_state == TS_RESET));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_be) &&
       $stable(mem_req_wdata)));

  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req_valid);

  a_r6_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_be == 4'b0001 || mem_req_be == 4'b0010 ||
                       mem_req_be == 4'b0100 || mem_req_be == 4'b1000 ||
                       mem_req_be == 4'b0011 || mem_req_be == 4'b1100 ||
                       mem_req_be == 4'b1111));

  a_r1_idle_in_reset: assert property (@(posedge clk)
    !rst_n |=> !mem_req_valid);
endmodule

bind sap_mem_port sap_mem_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tck(tck), .trst_n(trst_n), .tms(tms),
  .tap_state(tap_state), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/tb_sap_mem_port.sv
module tb_sap_mem_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b0, tdi = 1'b0;
  logic tdo;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [47:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  sap_mem_port dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [47:0] addr; logic wr; logic [3:0] be; logic [31:0] wdata;
  } exp_t;
  exp_t  sb[$];
  string sbtag[$];
  int checks = 0, fails = 0, accepted = 0, ncyc = 0, rsp_timer = 0;
  logic [47:0] rsp_addr;
  logic [7:0]  cur_ir = 8'hFF;
  logic [15:0] hi_cur = 16'h0;
  bit done = 0;

  function automatic logic [31:0] mem_fn(input logic [47:0] a);
    logic [31:0] w;
    w = a[33:2];
    return (w * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input logic [1:0] a);
    if (sz == 1) return 4'b0001 << a;
    if (sz == 2) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [63:0] mk_cmd(input logic [31:0] a, input logic [2:0] sz, input logic rd);
    return {16'h0, a, 3'b000, rd, sz, 9'h000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // memory model and scoreboard monitor, away from the rising edge
  always @(negedge clk) begin
    bit rdy;
    ncyc++;
    rdy = (ncyc % 3) != 1;
    mem_rsp_valid = 1'b0;
    if (rsp_timer != 0) begin
      rsp_timer--;
      if (rsp_timer == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = mem_fn(rsp_addr);
      end
    end
    if (rst_n && mem_req_valid && rdy) begin
      accepted++;
      if (sb.size() == 0) begin
        check(1'b0, "R7 unexpected request", {15'h0, mem_req_write, mem_req_addr}, 64'h0);
      end else begin
        exp_t  e;
        string t;
        e = sb.pop_front();
        t = sbtag.pop_front();
        check(e.addr == mem_req_addr && e.wr == mem_req_write && e.be == mem_req_be &&
              (!e.wr || e.wdata == mem_req_wdata), t,
              {mem_req_addr[15:0], mem_req_write, 3'b0, mem_req_be, 8'h0, mem_req_wdata},
              {e.addr[15:0], e.wr, 3'b0, e.be, 8'h0, e.wdata});
      end
      if (!mem_req_write) begin
        rsp_timer = 2;
        rsp_addr  = mem_req_addr;
      end
    end
    mem_req_ready = rdy;
  end

  task automatic tck_step(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    #50 o = tdo;
    #50 tck = 1'b1;
    #100 tck = 1'b0;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic b;
    dout = '0;
    tck_step(1, 0, b); tck_step(0, 0, b); tck_step(0, 0, b);
    for (int i = 0; i < n; i++) begin
      tck_step(i == n - 1, din[i], b);
      dout[i] = b;
    end
    tck_step(1, 0, b); tck_step(0, 0, b);
  endtask

  task automatic scan_ir(input logic [7:0] v, output logic [7:0] cap);
    logic b;
    tck_step(1, 0, b); tck_step(1, 0, b); tck_step(0, 0, b); tck_step(0, 0, b);
    for (int i = 0; i < 8; i++) begin
      tck_step(i == 7, v[i], b);
      cap[i] = b;
    end
    tck_step(1, 0, b); tck_step(0, 0, b);
    cur_ir = v;
  endtask

  task automatic set_ir(input logic [7:0] v);
    logic [7:0] c;
    if (cur_ir != v) scan_ir(v, c);
  endtask

  task automatic do_write(input logic [31:0] a, input int sz, input logic [31:0] d, input string tag);
    logic [63:0] x;
    logic [31:0] m;
    exp_t e;
    m = (sz == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * sz)) - 1);
    e.addr = {hi_cur, a}; e.wr = 1'b1; e.be = exp_be(sz, a[1:0]);
    e.wdata = (d & m) << (8 * a[1:0]);
    set_ir(8'h24);
    scan_dr(64, mk_cmd(a, 3'(sz), 1'b0), x);
    sb.push_back(e); sbtag.push_back(tag);
    set_ir(8'h25);
    scan_dr(8 * sz, {32'h0, d}, x);
  endtask

  task automatic do_read(input logic [31:0] a, input int sz, input string tag);
    logic [63:0] x, v, expv, m;
    exp_t e;
    m = (64'h1 << (8 * sz)) - 1;
    e.addr = {hi_cur, a}; e.wr = 1'b0; e.be = exp_be(sz, a[1:0]); e.wdata = '0;
    sb.push_back(e); sbtag.push_back({tag, " R4 request"});
    set_ir(8'h24);
    scan_dr(64, mk_cmd(a, 3'(sz), 1'b1), x);
    set_ir(8'h25);
    scan_dr(8 * sz, 64'h0, v);
    expv = {32'h0, mem_fn({hi_cur, a}) >> (8 * a[1:0])} & m;
    check(v == expv, {tag, " R5 read data"}, v, expv);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  c;
    logic        b;
    int          base;
    #95;
    check(mem_req_valid == 1'b0 && tdo == 1'b0, "R1 reset state", {mem_req_valid, tdo}, 0);
    #100 rst_n = 1'b1; trst_n = 1'b1;
    tck_step(0, 0, b);

    scan_ir(8'hFF, c);
    check(c == 8'h01, "R2 IR capture", c, 8'h01);

    scan_dr(8, 64'hB6, d);
    check(d[7:0] == 8'h6C, "R9 bypass 0xFF", d[7:0], 8'h6C);
    scan_ir(8'h33, c);
    scan_dr(8, 64'h5B, d);
    check(d[7:0] == 8'hB6, "R9 bypass unknown IR", d[7:0], 8'hB6);

    // R1: five TMS-high clocks
    set_ir(8'h24);
    for (int i = 0; i < 5; i++) tck_step(1, 0, b);
    tck_step(0, 0, b);
    cur_ir = 8'hFF;
    scan_dr(8, 64'hB6, d);
    check(d[7:0] == 8'h6C, "R1 TMS reset selects bypass", d[7:0], 8'h6C);

    // R1: trst_n
    set_ir(8'h24);
    #30 trst_n = 1'b0; #100 trst_n = 1'b1;
    cur_ir = 8'hFF;
    tck_step(0, 0, b);
    scan_dr(8, 64'hB6, d);
    check(d[7:0] == 8'h6C, "R1 trst selects bypass", d[7:0], 8'h6C);

    // R3 upper address
    set_ir(8'h21);
    scan_dr(16, 64'h0012, d);
    scan_dr(16, 64'h0012, d);
    check(d[15:0] == 16'h0012, "R3 upper address readback", d[15:0], 16'h0012);
    hi_cur = 16'h0012;
    do_write(32'h0000_1000, 4, 32'hDEAD_BEEF, "R3 R6 write size4 upper");
    set_ir(8'h21);
    scan_dr(16, 64'h0, d);
    hi_cur = 16'h0;

    // R6 writes across lanes
    for (int l = 0; l < 4; l++)
      do_write(32'h2000_0000 + l, 1, 32'hA0 + l, "R6 write size1");
    do_write(32'h2000_0010, 2, 32'h1234, "R6 write size2 low");
    do_write(32'h2000_0012, 2, 32'h5678, "R6 write size2 high");
    do_write(32'h2000_0020, 4, 32'hCAFE_F00D, "R6 write size4");

    // R5 reads, multi-element with advancing address
    for (int l = 0; l < 4; l++) do_read(32'h3000_0100 + l, 1, "R5 size1");
    do_read(32'h3000_0200, 2, "R5 size2 low");
    do_read(32'h3000_0202, 2, "R5 size2 high");
    for (int k = 0; k < 3; k++) do_read(32'h4000_0000 + 4 * k, 4, "R5 size4 burst");

    // R7 invalid commands produce no request
    #2000;
    base = accepted;
    set_ir(8'h24);
    scan_dr(64, mk_cmd(32'h5000_0000, 3'd3, 1'b1), d);
    scan_dr(64, mk_cmd(32'h5000_0000, 3'd0, 1'b0), d);
    set_ir(8'h25);
    scan_dr(32, 64'h1111_2222, d);
    set_ir(8'h24);
    scan_dr(64, mk_cmd(32'h5000_0000, 3'd4, 1'b1) | 64'h2000, d);
    scan_dr(64, mk_cmd(32'h5000_0000, 3'd4, 1'b0) | 64'h1, d);
    set_ir(8'h25);
    scan_dr(32, 64'h3333_4444, d);
    #4000;
    check(accepted == base, "R7 no request for bad command", accepted, base);

    // R8 all issued requests drained in order
    check(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule